// File: doc/BRIEF.md
# 4-bit Accumulator ALU with Skip

This block is the nibble-wide arithmetic and bit-manipulation datapath of a small microcontroller core. It owns the accumulator A, a general-purpose register B and an 8-bit output holding register E. Every clock it executes one operation. The operation comes from a 5-bit select, with a 4-bit immediate, the nibble that memory currently returns at the data pointer, and the current carry flag. It produces the new register values, a memory write (data plus a one-cycle enable), the new carry value and a skip request. The sequencer uses the skip request to suppress the next instruction.

Skip decisions are made in the same cycle as the arithmetic that causes them. This covers carry-dependent skips after additions, bit tests, the carry test and comparisons. The immediate add is special: it skips when the addition produces no carry out, but one immediate value (6 by default) never skips. The memory array, the pointer registers and the carry register itself are outside the block. The block returns the carry value that the surrounding logic should store, and passes `carryIn` through unchanged when an operation does not affect carry.

All outputs are registered. An operation presented before a rising clock edge has its results visible on the outputs after that edge.

Top module: `alu4_top`

Operation codes on `opSel`: 0 none, 1 copy B to A, 2 copy A to B, 3 pack {B,A} into E, 4 load immediate into A, 5 load memory into A, 6 swap A with memory, 7 add memory, 8 add memory with carry, 9 add memory with carry and skip, 10 add immediate, 11 set carry, 12 clear carry, 13 test carry, 14 invert A, 15 set memory bit, 16 clear memory bit, 17 test memory bit, 18 compare A with memory. Codes 19 to 31 behave as code 0.

## Requirements
- R1: While `rstN` is low, `accOut`, `regBOut`, `eOut`, `ramWrData`, `ramWrEn`, `carryOut` and `skipReq` are all 0.
- R2: Code 7 sets A to (A + ramRd) mod 16 and returns `carryOut` equal to `carryIn`, with no skip.
- R3: Codes 8 and 9 form A + ramRd + carryIn. Bit 4 of the sum becomes `carryOut` and bits 3:0 become A. Code 9 also raises `skipReq` when that new carry is 1, and code 8 never skips.
- R4: Code 10 sets A to (A + imm) mod 16 and raises `skipReq` when the sum is below 16. When imm equals 6 it never skips.
- R5: Code 14 inverts all four bits of A. Code 11 returns carry 1 and code 12 returns carry 0.
- R6: Code 13 raises `skipReq` exactly when `carryIn` is 0 and leaves A and the carry unchanged.
- R7: Codes 15 and 16 write `ramRd` back with bit imm[1:0] forced to 1 or 0 respectively.
- R8: Code 17 raises `skipReq` when bit imm[1:0] of `ramRd` is 0 and writes nothing.
- R9: Code 18 raises `skipReq` when A equals `ramRd`, and leaves A unchanged.
- R10: Code 1 copies B into A, code 2 copies A into B, and code 3 loads E with B in bits 7:4 and A in bits 3:0.
- R11: Code 5 loads A from `ramRd` without writing. Code 6 writes the old A as `ramWrData` and loads A from `ramRd` in the same cycle.
- R12: `ramWrEn` is high for exactly the cycle after a code 6, 15 or 16 is applied and low otherwise. `ramWrData` holds its last written value when there is no write. `skipReq` is low after every operation that has no skip condition.
- R13: Code 4 loads A with imm. Codes 0 and 19 to 31 change no register, write nothing, do not skip and return `carryIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 5 | Operation code for this cycle |
| imm | input | 4 | Immediate operand / bit index in bits 1:0 |
| ramRd | input | 4 | Nibble read from memory at the current pointer |
| carryIn | input | 1 | Current carry flag |
| accOut | output | 4 | Accumulator A |
| regBOut | output | 4 | Register B |
| eOut | output | 8 | Output holding register E |
| ramWrData | output | 4 | Nibble to write back to memory |
| ramWrEn | output | 1 | Memory write strobe, one cycle per write operation |
| carryOut | output | 1 | Carry value to be stored |
| skipReq | output | 1 | Request to skip the next instruction |

## Verification
Two functions meet in one cycle when a memory swap loads A and drives the old A onto the write port. The bench provokes this by presenting a `ramRd` that differs from the current A, then checks both values on the edge that follows. Carry generation and skip generation also share a cycle for the add-with-carry-and-skip and the immediate add. These are driven across carry-in/no-carry-in and overflow/no-overflow pairs, including the immediate value 6 with and without overflow. A behavioural reference model in the bench judges every cycle against all seven outputs.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_B2A    = 5'd1,
    OP_A2B    = 5'd2,
    OP_PACKE  = 5'd3,
    OP_LDI    = 5'd4,
    OP_LDM    = 5'd5,
    OP_SWAPM  = 5'd6,
    OP_ADDM   = 5'd7,
    OP_ADCM   = 5'd8,
    OP_ADCMS  = 5'd9,
    OP_ADDI   = 5'd10,
    OP_SETC   = 5'd11,
    OP_CLRC   = 5'd12,
    OP_TSTC   = 5'd13,
    OP_INVA   = 5'd14,
    OP_BSET   = 5'd15,
    OP_BCLR   = 5'd16,
    OP_BTST   = 5'd17,
    OP_CMPEQ  = 5'd18
  } opSel_e;

  typedef enum logic [2:0] {
    ASRC_B, ASRC_IMM, ASRC_RAM, ASRC_SUM, ASRC_INV
  } aSrc_e;

  typedef enum logic [1:0] {
    WSRC_ACC, WSRC_SETBIT, WSRC_CLRBIT
  } wSrc_e;

  typedef enum logic [1:0] {
    CY_KEEP, CY_SET, CY_CLR, CY_SUM
  } cySel_e;

  typedef enum logic [2:0] {
    SK_NONE, SK_NOCARRY_IMM, SK_CARRY, SK_CY_ZERO, SK_BIT_ZERO, SK_EQUAL
  } skSel_e;

  typedef struct packed {
    logic   loadA;
    aSrc_e  aSrc;
    logic   loadB;
    logic   loadE;
    logic   memWrite;
    wSrc_e  wSrc;
    logic   addImm;
    logic   addCarry;
    cySel_e cySel;
    skSel_e skSel;
  } strobe_s;

endpackage

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  opSel_e  op,
  output strobe_s strb
);

  always_comb begin
    strb = '{loadA: 1'b0, aSrc: ASRC_SUM, loadB: 1'b0, loadE: 1'b0,
             memWrite: 1'b0, wSrc: WSRC_ACC, addImm: 1'b0, addCarry: 1'b0,
             cySel: CY_KEEP, skSel: SK_NONE};
    case (op)
      OP_B2A:   begin strb.loadA = 1'b1; strb.aSrc = ASRC_B; end
      OP_A2B:   strb.loadB = 1'b1;
      OP_PACKE: strb.loadE = 1'b1;
      OP_LDI:   begin strb.loadA = 1'b1; strb.aSrc = ASRC_IMM; end
      OP_LDM:   begin strb.loadA = 1'b1; strb.aSrc = ASRC_RAM; end
      OP_SWAPM: begin
        strb.loadA = 1'b1; strb.aSrc = ASRC_RAM;
        strb.memWrite = 1'b1; strb.wSrc = WSRC_ACC;
      end
      OP_ADDM:  strb.loadA = 1'b1;
      OP_ADCM:  begin
        strb.loadA = 1'b1; strb.addCarry = 1'b1; strb.cySel = CY_SUM;
      end
      OP_ADCMS: begin
        strb.loadA = 1'b1; strb.addCarry = 1'b1; strb.cySel = CY_SUM;
        strb.skSel = SK_CARRY;
      end
      OP_ADDI:  begin
        strb.loadA = 1'b1; strb.addImm = 1'b1; strb.skSel = SK_NOCARRY_IMM;
      end
      OP_SETC:  strb.cySel = CY_SET;
      OP_CLRC:  strb.cySel = CY_CLR;
      OP_TSTC:  strb.skSel = SK_CY_ZERO;
      OP_INVA:  begin strb.loadA = 1'b1; strb.aSrc = ASRC_INV; end
      OP_BSET:  begin strb.memWrite = 1'b1; strb.wSrc = WSRC_SETBIT; end
      OP_BCLR:  begin strb.memWrite = 1'b1; strb.wSrc = WSRC_CLRBIT; end
      OP_BTST:  strb.skSel = SK_BIT_ZERO;
      OP_CMPEQ: strb.skSel = SK_EQUAL;
      default:  ;
    endcase
  end

endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int NOSKIP_IMM = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_s             strb,
  input  logic [DATA_W-1:0]   imm,
  input  logic [DATA_W-1:0]   ramRd,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   accQ,
  output logic [DATA_W-1:0]   regBQ,
  output logic [2*DATA_W-1:0] eQ,
  output logic [DATA_W-1:0]   ramWdQ,
  output logic                ramWeQ,
  output logic                carryQ,
  output logic                skipQ
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] addend;
  logic [SUM_W-1:0]  sum;
  logic              sumCarry;
  logic [DATA_W-1:0] bitMask;
  logic              selBit;
  logic [DATA_W-1:0] accNext;
  logic [DATA_W-1:0] wrNext;
  logic              carryNext;
  logic              skipNext;

  assign addend   = strb.addImm ? imm : ramRd;
  assign sum      = {1'b0, accQ} + {1'b0, addend}
                  + {{DATA_W{1'b0}}, strb.addCarry & carryIn};
  assign sumCarry = sum[DATA_W];
  assign bitMask  = DATA_W'(1) << imm[IDX_W-1:0];
  assign selBit   = |(ramRd & bitMask);

  always_comb begin
    case (strb.aSrc)
      ASRC_B:   accNext = regBQ;
      ASRC_IMM: accNext = imm;
      ASRC_RAM: accNext = ramRd;
      ASRC_INV: accNext = ~accQ;
      default:  accNext = sum[DATA_W-1:0];
    endcase
  end

  always_comb begin
    case (strb.wSrc)
      WSRC_SETBIT: wrNext = ramRd | bitMask;
      WSRC_CLRBIT: wrNext = ramRd & ~bitMask;
      default:     wrNext = accQ;
    endcase
  end

  always_comb begin
    case (strb.cySel)
      CY_SET:  carryNext = 1'b1;
      CY_CLR:  carryNext = 1'b0;
      CY_SUM:  carryNext = sumCarry;
      default: carryNext = carryIn;
    endcase
  end

  always_comb begin
    case (strb.skSel)
      SK_NOCARRY_IMM: skipNext = !sumCarry && (imm != DATA_W'(NOSKIP_IMM));
      SK_CARRY:       skipNext = sumCarry;
      SK_CY_ZERO:     skipNext = !carryIn;
      SK_BIT_ZERO:    skipNext = !selBit;
      SK_EQUAL:       skipNext = (accQ == ramRd);
      default:        skipNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      regBQ  <= '0;
      eQ     <= '0;
      ramWdQ <= '0;
      ramWeQ <= 1'b0;
      carryQ <= 1'b0;
      skipQ  <= 1'b0;
    end else begin
      if (strb.loadA)    accQ   <= accNext;
      if (strb.loadB)    regBQ  <= accQ;
      if (strb.loadE)    eQ     <= {regBQ, accQ};
      if (strb.memWrite) ramWdQ <= wrNext;
      ramWeQ <= strb.memWrite;
      carryQ <= carryNext;
      skipQ  <= skipNext;
    end
  end

  // A register must not change on an operation that does not load it (R13).
  assert_acc_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strb.loadA)) |-> $stable(accQ));

endmodule

// File: rtl/alu4_top.sv
module alu4_top
  import alu4_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int NOSKIP_IMM = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4:0]          opSel,
  input  logic [DATA_W-1:0]   imm,
  input  logic [DATA_W-1:0]   ramRd,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   accOut,
  output logic [DATA_W-1:0]   regBOut,
  output logic [2*DATA_W-1:0] eOut,
  output logic [DATA_W-1:0]   ramWrData,
  output logic                ramWrEn,
  output logic                carryOut,
  output logic                skipReq
);

  strobe_s strb;

  alu4_ctrl ctrl_i (
    .op   (opSel_e'(opSel)),
    .strb (strb)
  );

  alu4_datapath #(.DATA_W(DATA_W), .NOSKIP_IMM(NOSKIP_IMM)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .imm     (imm),
    .ramRd   (ramRd),
    .carryIn (carryIn),
    .accQ    (accOut),
    .regBQ   (regBOut),
    .eQ      (eOut),
    .ramWdQ  (ramWrData),
    .ramWeQ  (ramWrEn),
    .carryQ  (carryOut),
    .skipQ   (skipReq)
  );

  // Write strobe only follows a swap, bit-set or bit-clear code.
  assert_we_source_R12: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> ($past(rstN) && ($past(opSel) == 5'd6 || $past(opSel) == 5'd15
                                 || $past(opSel) == 5'd16)));

  // Plain add from memory leaves carry as given.
  assert_addm_carry_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 5'd7) |-> (carryOut == $past(carryIn)));

  // Immediate add with the special value never skips.
  assert_addi_special_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 5'd10 && $past(imm) == DATA_W'(NOSKIP_IMM))
      |-> !skipReq);

  // Set carry returns 1.
  assert_setc_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 5'd11) |-> carryOut);

  // Swap: old A goes out, memory value comes in.
  assert_swap_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 5'd6)
      |-> (ramWrData == $past(accOut) && accOut == $past(ramRd)));

  // Compare skip follows equality.
  assert_cmpeq_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == 5'd18)
      |-> (skipReq == ($past(accOut) == $past(ramRd))));

endmodule

// File: tb/alu4_top_tb.sv
module alu4_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] opSel = '0;
  logic [3:0] imm = '0;
  logic [3:0] ramRd = '0;
  logic       carryIn = 1'b0;
  logic [3:0] accOut, regBOut, ramWrData;
  logic [7:0] eOut;
  logic       ramWrEn, carryOut, skipReq;

  int nChecks = 0;
  int nFails  = 0;

  // reference state
  int mA = 0, mB = 0, mE = 0, mWd = 0, mWe = 0, mCy = 0, mSk = 0;

  always #5 clk = ~clk;

  alu4_top dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .imm(imm), .ramRd(ramRd),
    .carryIn(carryIn), .accOut(accOut), .regBOut(regBOut), .eOut(eOut),
    .ramWrData(ramWrData), .ramWrEn(ramWrEn), .carryOut(carryOut),
    .skipReq(skipReq)
  );

  function automatic string reqOf(input int op);
    case (op)
      1, 2, 3:  return "R10";
      4:        return "R13";
      5, 6:     return "R11";
      7:        return "R2";
      8, 9:     return "R3";
      10:       return "R4";
      11, 12, 14: return "R5";
      13:       return "R6";
      15, 16:   return "R7";
      17:       return "R8";
      18:       return "R9";
      default:  return "R13";
    endcase
  endfunction

  task automatic compareAll(input string req);
    nChecks++;
    if (accOut !== 4'(mA) || regBOut !== 4'(mB) || eOut !== 8'(mE) ||
        ramWrData !== 4'(mWd) || ramWrEn !== 1'(mWe) ||
        carryOut !== 1'(mCy) || skipReq !== 1'(mSk)) begin
      nFails++;
      $display("FAIL %s: got A=%0h B=%0h E=%0h wd=%0h we=%0b cy=%0b sk=%0b exp A=%0h B=%0h E=%0h wd=%0h we=%0d cy=%0d sk=%0d",
               req, accOut, regBOut, eOut, ramWrData, ramWrEn, carryOut, skipReq,
               mA, mB, mE, mWd, mWe, mCy, mSk);
    end
  endtask

  task automatic model(input int op, input int n, input int m, input int c);
    int s;
    int mask;
    mask = 1 << (n & 3);
    mWe = 0; mSk = 0; mCy = c;
    case (op)
      1:  mA = mB;
      2:  mB = mA;
      3:  mE = mB * 16 + mA;
      4:  mA = n;
      5:  mA = m;
      6:  begin mWd = mA; mWe = 1; mA = m; end
      7:  mA = (mA + m) % 16;
      8, 9: begin
        s = mA + m + c; mA = s % 16; mCy = s / 16;
        if (op == 9) mSk = mCy;
      end
      10: begin s = mA + n; mA = s % 16; mSk = (s < 16 && n != 6) ? 1 : 0; end
      11: mCy = 1;
      12: mCy = 0;
      13: mSk = (c == 0) ? 1 : 0;
      14: mA = (~mA) & 15;
      15: begin mWd = m | mask; mWe = 1; end
      16: begin mWd = m & ~mask & 15; mWe = 1; end
      17: mSk = ((m & mask) == 0) ? 1 : 0;
      18: mSk = (mA == m) ? 1 : 0;
      default: ;
    endcase
  endtask

  task automatic doOp(input int op, input int n, input int m, input int c);
    @(negedge clk);
    opSel = 5'(op); imm = 4'(n); ramRd = 4'(m); carryIn = 1'(c);
    model(op, n, m, c);
    @(posedge clk);
    #2;
    compareAll(reqOf(op));
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    // R1: reset state, with a write op presented during reset
    opSel = 5'd15; ramRd = 4'hf; carryIn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    compareAll("R1");
    @(negedge clk);
    rstN = 1'b1;
    opSel = 5'd0; carryIn = 1'b0;

    // R13 load immediate, R10 transfers
    doOp(4, 9, 0, 0);
    doOp(2, 0, 0, 0);
    doOp(4, 3, 0, 0);
    doOp(3, 0, 0, 0);   // E = 0x93
    doOp(1, 0, 0, 1);   // A = 9
    // R11 plain load and swap with differing values
    doOp(5, 0, 4'hc, 0);
    doOp(6, 0, 4'h5, 1);
    doOp(6, 0, 4'h5, 0);
    // R2 add memory, carry passes through, overflow wraps
    doOp(7, 0, 4'hd, 1);
    doOp(7, 0, 4'h1, 0);
    // R3 add with carry, with and without skip variant
    doOp(4, 15, 0, 0);
    doOp(8, 0, 0, 1);
    doOp(4, 7, 0, 0);
    doOp(9, 0, 8, 1);
    doOp(9, 0, 2, 0);
    // R4 immediate add: overflow, no overflow, special value both ways
    doOp(4, 12, 0, 0);
    doOp(10, 5, 0, 0);
    doOp(10, 2, 0, 0);
    doOp(10, 6, 0, 0);
    doOp(4, 14, 0, 0);
    doOp(10, 6, 0, 0);
    // R5 / R6 carry ops, invert
    doOp(11, 0, 0, 0);
    doOp(12, 0, 0, 1);
    doOp(13, 0, 0, 0);
    doOp(13, 0, 0, 1);
    doOp(14, 0, 0, 0);
    // R7 / R8 bit ops on each index
    for (int i = 0; i < 4; i++) begin
      doOp(15, i, 4'h0, 0);
      doOp(16, i, 4'hf, 0);
      doOp(17, i, 4'h5, 0);
    end
    // R9 compare equal and unequal
    doOp(4, 6, 0, 0);
    doOp(18, 0, 6, 0);
    doOp(18, 0, 7, 0);
    // R12 back-to-back writes, then idle; R13 unused codes
    doOp(15, 1, 2, 0);
    doOp(6, 0, 3, 0);
    doOp(0, 0, 9, 1);
    doOp(25, 7, 9, 1);
    doOp(31, 3, 1, 0);
    // mixed stream
    for (int k = 0; k < 600; k++)
      doOp(int'($urandom_range(0, 31)), int'($urandom_range(0, 15)),
           int'($urandom_range(0, 15)), int'($urandom_range(0, 1)));
    summary();
  end

endmodule